// File: doc/BRIEF.md
# Retransmit-capable transmit packet FIFO

This block is a byte-wide buffer that sits between a host-side DMA writer and a MAC-side transmitter. The writer pushes frames one byte at a time and flags the final byte of each frame. The transmitter reads a frame out and then gives its verdict. A done pulse releases the frame's space. A retry pulse, issued after a collision, rewinds reading to the frame's first byte so the frame goes out again from the buffer and the host does not fetch it a second time.

Space is released only by done, so bytes that have been read but not yet released still occupy the buffer. Up to two complete frames can be held at once, so the next frame is already staged while the current one is on the wire. This keeps back-to-back frames at the minimum inter-frame gap. Both sides share one clock and one synchronous active-low reset.

Top module: `tx_retry_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `frame_count` is 0, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Bytes are read out in the order they were written. `rd_last` is 1 exactly on the byte that was written with `wr_last` = 1.
- R3: `rd_valid` is 1 only while at least one complete frame (final byte written) is held. `empty` is 1 exactly when no complete frame is held. A frame that is still being written cannot be read.
- R4: At most MAX_FRAMES (default 2) complete frames are held. While that many are held and no frame is being written, `wr_ready` is 0, so the first byte of a further frame is refused.
- R5: The buffer holds DEPTH (default 2048) bytes, counted from the first byte of the oldest unreleased frame. Bytes that have been read but not released count toward this. When DEPTH bytes are held, `full` is 1 and `wr_ready` is 0.
- R6: After the final byte of a frame is read, `rd_valid` stays 0 until done or retry is accepted.
- R7: `rd_done` asserted after the final byte has been read releases the frame. `frame_count` drops by one, its bytes are freed, and the next frame becomes readable from its first byte.
- R8: `rd_retry` while a frame is in progress (at least one byte read, or the final byte read and awaiting a verdict) rewinds reading to that frame's first byte. It leaves `frame_count` and the occupied space unchanged, and a read accepted in the same cycle is discarded.
- R9: `rd_retry` while no frame is in progress has no effect: the next byte read is still the oldest frame's first byte and the counts do not change.
- R10: `rd_done` before the final byte has been read is ignored. The frame is kept and reading continues with the next unread byte.
- R11: When `rd_retry` and `rd_done` are both accepted candidates in the same cycle, retry wins and the frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Writer offers a byte |
| wr_ready | output | 1 | Buffer takes the offered byte this cycle |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Offered byte ends its frame |
| rd_valid | output | 1 | A byte of a complete frame is available |
| rd_ready | input | 1 | Transmitter takes the current byte |
| rd_data | output | 8 | Current byte |
| rd_last | output | 1 | Current byte ends its frame |
| rd_done | input | 1 | Frame sent successfully; release it |
| rd_retry | input | 1 | Frame collided; rewind to its first byte |
| frame_count | output | 2 | Number of complete frames held |
| empty | output | 1 | No complete frame held |
| full | output | 1 | DEPTH bytes held |

## Verification
The hardest situation to reach is a full buffer in which part of the stored space belongs to a frame that has already been read completely but not yet released. The bench builds it directly. It writes two 1100-byte frames with the reader stalled, so the second frame runs into the 2048-byte limit mid-write. It then reads the first frame to its end and withholds done, so the buffer must stay full until done arrives. Long random runs follow, mixing short and near-maximum frames with sparse retry and stray done pulses, and a bench model predicts every output on every cycle.

// File: rtl/tfq_pkg.sv
// Package for the transmit retry FIFO.
// Holds the stored entry layout: one data byte plus a frame-end flag.
package tfq_pkg;
    localparam int TFQ_DW = 8;

    typedef struct packed {
        logic              last;
        logic [TFQ_DW-1:0] data;
    } tfq_entry_t;
endpackage

// File: rtl/tfq_store.sv
// Storage array for the transmit retry FIFO.
// Has one write port and one combinational read port.
// Assumes the caller never writes a slot that still holds unreleased data.
module tfq_store
    import tfq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        we,
    input  logic [AW-1:0] waddr,
    input  tfq_entry_t  wentry,
    input  logic [AW-1:0] raddr,
    output tfq_entry_t  rentry
);
    tfq_entry_t mem [DEPTH];

    // Store one entry per accepted write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    // Present the entry at the read pointer.
    assign rentry = mem[raddr];
endmodule

// File: rtl/tfq_wr_ctrl.sv
// Write-side control for the transmit retry FIFO.
// Keeps the write pointer and tracks whether a frame is partly written.
// Assumes `used` is counted from the committed start, not the read pointer.
module tfq_wr_ctrl #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  logic [PW-1:0] used,
    input  logic          frames_at_cap,
    output logic          wr_ready,
    output logic          wr_fire,
    output logic          frame_end,
    output logic          wr_open,
    output logic [PW-1:0] wr_ptr
);
    logic space_left;

    // A byte fits if space remains; a new frame also needs a free frame slot.
    assign space_left = (used != PW'(DEPTH));
    assign wr_ready   = space_left && (wr_open || !frames_at_cap);
    assign wr_fire    = wr_valid && wr_ready;
    assign frame_end  = wr_fire && wr_last;

    // Advance the write pointer and track the open-frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_open <= 1'b0;
        end else if (wr_fire) begin
            wr_ptr  <= wr_ptr + PW'(1);
            wr_open <= !wr_last;
        end
    end

    AST_NEW_FRAME_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !wr_open) |-> !frames_at_cap);    // R4
endmodule

// File: rtl/tfq_rd_ctrl.sv
// Read-side control for the transmit retry FIFO.
// Keeps the live read pointer and the committed start of the oldest frame.
// Done moves the committed start up to the read pointer.
// Retry moves the read pointer back to the committed start.
// Assumes `have_frame` is high only while a complete frame is stored.
module tfq_rd_ctrl #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          have_frame,
    input  logic          entry_last,
    input  logic          rd_ready,
    input  logic          rd_retry,
    input  logic          rd_done,
    output logic          rd_valid,
    output logic          retry_acc,
    output logic          done_acc,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] commit_ptr
);
    logic hold;    // final byte read, waiting for a verdict
    logic busy;    // a frame is in progress on the read side
    logic rd_fire;

    // Decode the verdict inputs; retry takes priority over done.
    assign busy      = hold || (rd_ptr != commit_ptr);
    assign retry_acc = rd_retry && busy;
    assign done_acc  = rd_done && hold && !retry_acc;
    assign rd_valid  = have_frame && !hold;
    assign rd_fire   = rd_valid && rd_ready && !retry_acc;

    // Move the read pointer, the committed start and the hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            commit_ptr <= '0;
            hold       <= 1'b0;
        end else if (retry_acc) begin
            rd_ptr <= commit_ptr;
            hold   <= 1'b0;
        end else if (done_acc) begin
            commit_ptr <= rd_ptr;
            hold       <= 1'b0;
        end else if (rd_fire) begin
            rd_ptr <= rd_ptr + PW'(1);
            hold   <= entry_last;
        end
    end

    AST_RETRY_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        retry_acc |=> (commit_ptr == $past(commit_ptr)) && (rd_ptr == commit_ptr));    // R8
    AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !hold) |=> (commit_ptr == $past(commit_ptr)));    // R10
endmodule

// File: rtl/tfq_frame_cnt.sv
// Complete-frame counter for the transmit retry FIFO.
// Counts up when a frame's final byte is written.
// Counts down when a frame is released.
// Assumes the writer side never completes a frame while the count is at its cap.
module tfq_frame_cnt #(
    parameter int MAX_FRAMES = 2,
    localparam int CW        = $clog2(MAX_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          at_cap
);
    assign at_cap = (count == CW'(MAX_FRAMES));

    // Track complete frames held in the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tx_retry_fifo.sv
// Transmit packet FIFO with retransmit support.
// Frames enter byte by byte with an end flag and leave in order.
// A frame's space is freed only by done; retry replays it from the buffer.
// Assumes DEPTH is a power of two and that both sides share clk.
module tx_retry_fifo
    import tfq_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int MAX_FRAMES = 2,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1,
    localparam int CW        = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [TFQ_DW-1:0] wr_data,
    input  logic              wr_last,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [TFQ_DW-1:0] rd_data,
    output logic              rd_last,
    input  logic              rd_done,
    input  logic              rd_retry,
    output logic [CW-1:0]     frame_count,
    output logic              empty,
    output logic              full
);
    logic          wr_fire, frame_end, wr_open, at_cap;
    logic          retry_acc, done_acc;
    logic [PW-1:0] wr_ptr, rd_ptr, commit_ptr, used;
    tfq_entry_t    wentry, rentry;

    // Occupancy counted from the oldest unreleased byte.
    assign used   = wr_ptr - commit_ptr;
    assign wentry = '{last: wr_last, data: wr_data};

    tfq_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
        .used(used), .frames_at_cap(at_cap), .wr_ready(wr_ready),
        .wr_fire(wr_fire), .frame_end(frame_end), .wr_open(wr_open),
        .wr_ptr(wr_ptr)
    );

    tfq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_fire), .waddr(wr_ptr[AW-1:0]), .wentry(wentry),
        .raddr(rd_ptr[AW-1:0]), .rentry(rentry)
    );

    tfq_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .have_frame(frame_count != '0),
        .entry_last(rentry.last), .rd_ready(rd_ready), .rd_retry(rd_retry),
        .rd_done(rd_done), .rd_valid(rd_valid), .retry_acc(retry_acc),
        .done_acc(done_acc), .rd_ptr(rd_ptr), .commit_ptr(commit_ptr)
    );

    tfq_frame_cnt #(.MAX_FRAMES(MAX_FRAMES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(frame_end), .dec(done_acc),
        .count(frame_count), .at_cap(at_cap)
    );

    // Drive the read-side data and the status flags.
    assign rd_data = rentry.data;
    assign rd_last = rentry.last;
    assign empty   = (frame_count == '0);
    assign full    = (used == PW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));    // R5
    AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_count <= CW'(MAX_FRAMES));    // R4
    AST_THIRD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (at_cap && !wr_open) |-> !wr_ready);    // R4
    AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_valid);    // R3
    AST_HOLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last && !rd_retry) |=> !rd_valid);    // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && !frame_end) |=> frame_count == $past(frame_count) - CW'(1));    // R7
    AST_RETRY_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_acc |=> (frame_count >= $past(frame_count)) && rd_valid);    // R8
    AST_RETRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_retry && rd_done) |=> frame_count >= $past(frame_count));    // R11
endmodule

// File: tb/test_tx_retry_fifo.sv
`timescale 1ns/1ps
module test_tx_retry_fifo;
    localparam int DEPTH = 2048;
    localparam int MAXF  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_last = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_ready = 1'b0, rd_done = 1'b0, rd_retry = 1'b0;
    logic       wr_ready, rd_valid, rd_last, empty, full;
    logic [7:0] rd_data;
    logic [1:0] frame_count;

    int checks = 0, errors = 0;

    // Reference model state
    logic [8:0] mq[$];
    int m_used = 0, m_frames = 0, m_rd_off = 0;
    bit m_open = 0, m_hold = 0, m_wfire = 0;

    // Writer generator state
    int g_len = 0, g_idx = 0, g_fno = 0;
    bit long_mode = 0;

    always #10 clk = ~clk;

    tx_retry_fifo #(.DEPTH(DEPTH), .MAX_FRAMES(MAXF)) i_tx_retry_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_last(wr_last), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
        .rd_done(rd_done), .rd_retry(rd_retry), .frame_count(frame_count),
        .empty(empty), .full(full)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_wr_ready();
        return (m_used < DEPTH) && (m_open || m_frames < MAXF);
    endfunction

    function automatic bit exp_rd_valid();
        return (m_frames > 0) && !m_hold;
    endfunction

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        bit wf, busy, ra, da, rf;
        wf   = wr_valid && exp_wr_ready();
        busy = m_hold || (m_rd_off != 0);
        ra   = rd_retry && busy;
        da   = rd_done && m_hold && !ra;
        rf   = rd_ready && exp_rd_valid() && !ra;
        if (rf) begin
            if (mq[m_rd_off][8]) m_hold = 1;
            m_rd_off++;
        end
        if (ra) begin
            m_rd_off = 0;
            m_hold = 0;
        end
        if (da) begin
            for (int k = 0; k < m_rd_off; k++) void'(mq.pop_front());
            m_used -= m_rd_off;
            m_rd_off = 0;
            m_hold = 0;
            m_frames--;
        end
        if (wf) begin
            mq.push_back({wr_last, wr_data});
            m_used++;
            m_open = !wr_last;
            if (wr_last) m_frames++;
        end
        m_wfire = wf;
    endtask

    task automatic compare_all();
        chk("R4 R5", "wr_ready", int'(wr_ready), int'(exp_wr_ready()));
        chk("R3 R6", "rd_valid", int'(rd_valid), int'(exp_rd_valid()));
        chk("R7 R9", "frame_count", int'(frame_count), m_frames);
        chk("R3", "empty", int'(empty), int'(m_frames == 0));
        chk("R5", "full", int'(full), int'(m_used == DEPTH));
        if (exp_rd_valid()) begin
            chk("R2 R8", "rd_data", int'(rd_data), int'(mq[m_rd_off][7:0]));
            chk("R2", "rd_last", int'(rd_last), int'(mq[m_rd_off][8]));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit wv, input logic [7:0] wd, input bit wl,
                         input bit rr, input bit rt, input bit dn);
        wr_valid = wv; wr_data = wd; wr_last = wl;
        rd_ready = rr; rd_retry = rt; rd_done = dn;
        cycle();
    endtask

    // One cycle of generated traffic; rp is the read-ready percentage.
    task automatic gen_cycle(input int wp, input int rp, input bit allow_verdict);
        if (g_len == 0) begin
            g_idx = 0;
            if (long_mode) g_len = 1100;
            else if ($urandom % 100 < 15) g_len = 200 + int'($urandom % 1300);
            else g_len = 1 + int'($urandom % 64);
        end
        wr_valid = ($urandom % 100) < wp;
        wr_data  = 8'(g_fno * 7 + g_idx);
        wr_last  = (g_idx == g_len - 1);
        rd_ready = ($urandom % 100) < rp;
        rd_retry = allow_verdict && (($urandom % 100) < 3);
        rd_done  = allow_verdict && (m_hold ? (($urandom % 100) < 60) : (($urandom % 100) < 3));
        cycle();
        if (m_wfire) begin
            g_idx++;
            if (g_idx == g_len) begin
                g_len = 0;
                g_fno++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "frame_count", int'(frame_count), 0);
        chk("R1", "wr_ready", int'(wr_ready), 1);
        chk("R1", "rd_valid", int'(rd_valid), 0);

        // R9: retry with nothing in progress
        drive(0, 0, 0, 0, 1, 0);
        chk("R9", "frame_count", int'(frame_count), 0);
        chk("R9", "empty", int'(empty), 1);

        // Write a 4-byte frame A0..A3
        for (int i = 0; i < 4; i++) drive(1, 8'hA0 + 8'(i), i == 3, 0, 0, 0);
        chk("R3", "rd_valid", int'(rd_valid), 1);
        chk("R2", "rd_data", int'(rd_data), 'hA0);
        drive(0, 0, 0, 0, 1, 0);    // R9: retry before any byte read
        chk("R9", "rd_data", int'(rd_data), 'hA0);

        // R10: early done is ignored
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 1);
        chk("R10", "frame_count", int'(frame_count), 1);
        chk("R10", "rd_data", int'(rd_data), 'hA2);
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0, 0);
        chk("R6", "rd_valid", int'(rd_valid), 0);

        // R11: retry and done together, retry wins
        drive(0, 0, 0, 0, 1, 1);
        chk("R11", "frame_count", int'(frame_count), 1);
        chk("R11", "rd_data", int'(rd_data), 'hA0);

        // R8: retry mid-frame
        drive(0, 0, 0, 1, 0, 0);
        chk("R8", "rd_data", int'(rd_data), 'hA1);
        drive(0, 0, 0, 0, 1, 0);
        chk("R8", "rd_data", int'(rd_data), 'hA0);

        // R7: full read then done releases
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 1);
        chk("R7", "frame_count", int'(frame_count), 0);
        chk("R7", "empty", int'(empty), 1);

        // R5: fill with two long frames while the reader is stalled
        long_mode = 1;
        for (int i = 0; i < 2400; i++) gen_cycle(100, 0, 0);
        chk("R5", "full", int'(full), 1);
        chk("R5", "wr_ready", int'(wr_ready), 0);
        for (int i = 0; i < 1200; i++) gen_cycle(100, 100, 0);
        chk("R5", "full after read, no done", int'(full), 1);
        chk("R6", "rd_valid awaiting verdict", int'(rd_valid), 0);
        rd_ready = 0;
        wr_valid = 0;
        drive(0, 0, 0, 0, 0, 1);
        chk("R7", "full after done", int'(full), 0);
        long_mode = 0;

        // Mixed random traffic
        for (int i = 0; i < 20000; i++) gen_cycle(80, 60, 1);
        for (int i = 0; i < 20000; i++) gen_cycle(90, 15, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule